// File: doc/BRIEF.md
# Shared-Bus Multiplexor Interconnect

This block is the central crossbar-free interconnect of a pipelined shared bus with three masters and four slaves. An external arbiter supplies a grant index. The grant picks which master's address and control reach every slave in the current address phase. An address decoder turns that address into one select line per slave. Addresses outside the mapped window go to a built-in default responder.

Each transfer has a one-cycle address phase and a data phase of one or more cycles. The address phase of the next transfer overlaps the data phase of the current one. Two small registers record which slave and which master own the data phase. They load only on a cycle where the global ready is high. These registers steer the write data toward the slaves and the read data and response back toward the masters. The global ready comes from the slave that owns the data phase. It is sent back to every master and slave, so a slave that holds ready low also stretches the address phase that follows.

Top module: `shared_bus_ic`

## Requirements
- R1: The slave-side address, transfer type, direction and size equal the fields of the master named by `grant`, in the same cycle.
- R2: An address whose bits [31:30] are zero drives exactly the select `s_sel[addr[29:28]]`. Any other address drives no select and is served by the default responder.
- R3: `bus_ready` equals the ready of the slave that was addressed in the last address phase accepted with `bus_ready` high. The owner of the data phase stays fixed while `bus_ready` is low, even when the grant or address changes.
- R4: When a read completes, `m_rdata` and `m_resp` carry the data and response of the slave that owns the data phase. The response code for OK is 2'b00.
- R5: For every cycle of a write data phase, including wait states, `s_wdata` carries the write data of the master that issued that transfer.
- R6: An active transfer (type 2'b10 or 2'b11) to an unmapped address gets two cycles of ERROR (2'b01). In the first cycle `bus_ready` is low and in the second it is high. The read data is zero.
- R7: An idle (2'b00) or busy (2'b01) transfer to an unmapped address completes with zero wait states and an OK response.
- R8: During and right after reset, the data phase belongs to the default responder: `bus_ready` is high, `m_resp` is OK and `m_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 2 | Index of the master that owns the address phase |
| m_addr | input | 96 | Master addresses, 32 bits per master |
| m_trans | input | 6 | Master transfer types, 2 bits per master |
| m_write | input | 3 | Master direction, 1 = write |
| m_size | input | 9 | Master transfer sizes, 3 bits per master |
| m_burst | input | 9 | Master burst kinds, 3 bits per master |
| m_wdata | input | 96 | Master write data, 32 bits per master |
| m_rdata | output | 32 | Read data returned to all masters |
| m_resp | output | 2 | Response returned to all masters |
| bus_ready | output | 1 | Global ready to masters and slaves |
| s_addr | output | 32 | Broadcast address |
| s_trans | output | 2 | Broadcast transfer type |
| s_write | output | 1 | Broadcast direction |
| s_size | output | 3 | Broadcast size |
| s_burst | output | 3 | Broadcast burst kind |
| s_wdata | output | 32 | Write data of the data-phase owner |
| s_sel | output | 4 | One select per slave |
| s_rdata | input | 128 | Slave read data, 32 bits per slave |
| s_resp | input | 2*4 | Slave responses, 2 bits per slave |
| s_ready_out | input | 4 | Per-slave ready |

## Verification
The assertions rely on three things about the inputs. A master keeps its write data unchanged while its data phase is stretched. No mapped slave returns ERROR with its own ready low. The grant never points at a master index that does not exist. The bench models the slaves and masters within these limits: an owner drives a fixed pattern for the whole data phase, the slave models answer only OK, and the grant is drawn from 0 to 2. The bench also changes the stalled address phase and the write data of the non-owning masters on purpose, to show that only the registered owners steer the data-phase paths.

// File: rtl/bus_ic_pkg.sv
package bus_ic_pkg;

    localparam int AW      = 32;
    localparam int DW      = 32;
    localparam int N_MST   = 3;
    localparam int N_SLV   = 4;
    localparam int SZ_W    = 3;
    localparam int BU_W    = 3;
    localparam int REG_LSB = 28;
    localparam int REG_W   = $clog2(N_SLV);
    localparam int MIDX_W  = (N_MST > 1) ? $clog2(N_MST) : 1;
    localparam int SIDX_W  = $clog2(N_SLV + 1);
    localparam logic [SIDX_W-1:0] DEF_IDX = SIDX_W'(N_SLV);

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } resp_e;

    typedef struct packed {
        logic [AW-1:0]   addr;
        trans_e          trans;
        logic            write;
        logic [SZ_W-1:0] size;
        logic [BU_W-1:0] burst;
    } actl_t;

    localparam int ACTL_W = $bits(actl_t);

    function automatic logic trans_active(input trans_e t);
        return (t == TR_NONSEQ) || (t == TR_SEQ);
    endfunction

    function automatic logic addr_mapped(input logic [AW-1:0] a);
        return a[AW-1:REG_LSB+REG_W] == '0;
    endfunction

    function automatic logic [REG_W-1:0] addr_region(input logic [AW-1:0] a);
        return a[REG_LSB +: REG_W];
    endfunction

endpackage

// File: rtl/ic_mux.sv
module ic_mux #(
    parameter int N  = 3,
    parameter int W  = 32,
    parameter int IW = 2
) (
    input  logic [IW-1:0]       sel,
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        dout
);
    // Out-of-range index yields zero.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == IW'(i)) dout = din[i];
        end
    end
endmodule

// File: rtl/ic_decoder.sv
module ic_decoder
    import bus_ic_pkg::*;
(
    input  logic [AW-1:0]     addr,
    output logic [N_SLV-1:0]  sel,
    output logic [SIDX_W-1:0] idx
);
    logic             hit;
    logic [REG_W-1:0] region;

    assign hit    = addr_mapped(addr);
    assign region = addr_region(addr);

    for (genvar s = 0; s < N_SLV; s++) begin : g_sel
        assign sel[s] = hit && (region == REG_W'(s));
    end

    assign idx = hit ? SIDX_W'(region) : DEF_IDX;
endmodule

// File: rtl/ic_default_slave.sv
module ic_default_slave
    import bus_ic_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel,
    input  trans_e trans,
    input  logic   bus_ready,
    output logic   ready_out,
    output resp_e  resp
);
    typedef enum logic [1:0] {DS_OK, DS_ERR_WAIT, DS_ERR_END} ds_state_e;

    ds_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (state_q == DS_ERR_WAIT) begin
            state_d = DS_ERR_END;
        end else if (bus_ready) begin
            state_d = (sel && trans_active(trans)) ? DS_ERR_WAIT : DS_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DS_OK;
        else     state_q <= state_d;
    end

    assign ready_out = (state_q != DS_ERR_WAIT);
    assign resp      = (state_q == DS_OK) ? RSP_OKAY : RSP_ERROR;
endmodule

// File: rtl/ic_rsp_mux.sv
module ic_rsp_mux
    import bus_ic_pkg::*;
(
    input  logic [SIDX_W-1:0]          idx,
    input  logic [N_SLV-1:0][DW-1:0]   rdata,
    input  logic [N_SLV-1:0][1:0]      resp,
    input  logic [N_SLV-1:0]           ready,
    input  resp_e                      def_resp,
    input  logic                       def_ready,
    output logic [DW-1:0]              rdata_out,
    output resp_e                      resp_out,
    output logic                       ready_out
);
    always_comb begin
        rdata_out = '0;
        resp_out  = def_resp;
        ready_out = def_ready;
        for (int s = 0; s < N_SLV; s++) begin
            if (idx == SIDX_W'(s)) begin
                rdata_out = rdata[s];
                resp_out  = resp_e'(resp[s]);
                ready_out = ready[s];
            end
        end
    end
endmodule

// File: rtl/shared_bus_ic.sv
module shared_bus_ic
    import bus_ic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [MIDX_W-1:0]       grant,
    input  logic [N_MST*AW-1:0]     m_addr,
    input  logic [N_MST*2-1:0]      m_trans,
    input  logic [N_MST-1:0]        m_write,
    input  logic [N_MST*SZ_W-1:0]   m_size,
    input  logic [N_MST*BU_W-1:0]   m_burst,
    input  logic [N_MST*DW-1:0]     m_wdata,
    output logic [DW-1:0]           m_rdata,
    output logic [1:0]              m_resp,
    output logic                    bus_ready,
    output logic [AW-1:0]           s_addr,
    output logic [1:0]              s_trans,
    output logic                    s_write,
    output logic [SZ_W-1:0]         s_size,
    output logic [BU_W-1:0]         s_burst,
    output logic [DW-1:0]           s_wdata,
    output logic [N_SLV-1:0]        s_sel,
    input  logic [N_SLV*DW-1:0]     s_rdata,
    input  logic [N_SLV*2-1:0]      s_resp,
    input  logic [N_SLV-1:0]        s_ready_out
);
    // Address phase: pack each master's fields, pick the granted one.
    actl_t [N_MST-1:0] m_ctl;
    logic [ACTL_W-1:0] ap_bits;
    actl_t             ap_ctl;

    for (genvar m = 0; m < N_MST; m++) begin : g_pack
        assign m_ctl[m] = '{
            addr:  m_addr[m*AW +: AW],
            trans: trans_e'(m_trans[m*2 +: 2]),
            write: m_write[m],
            size:  m_size[m*SZ_W +: SZ_W],
            burst: m_burst[m*BU_W +: BU_W]
        };
    end

    ic_mux #(.N(N_MST), .W(ACTL_W), .IW(MIDX_W)) u_amux (
        .sel  (grant),
        .din  (m_ctl),
        .dout (ap_bits)
    );
    assign ap_ctl = actl_t'(ap_bits);

    assign s_addr  = ap_ctl.addr;
    assign s_trans = ap_ctl.trans;
    assign s_write = ap_ctl.write;
    assign s_size  = ap_ctl.size;
    assign s_burst = ap_ctl.burst;

    logic [SIDX_W-1:0] ap_slv;

    ic_decoder u_dec (
        .addr (ap_ctl.addr),
        .sel  (s_sel),
        .idx  (ap_slv)
    );

    // Data-phase owners: load only when the current data phase completes.
    logic [SIDX_W-1:0] dp_slv_q;
    logic [MIDX_W-1:0] dp_mst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_slv_q <= DEF_IDX;
            dp_mst_q <= '0;
        end else if (bus_ready) begin
            dp_slv_q <= ap_slv;
            dp_mst_q <= grant;
        end
    end

    ic_mux #(.N(N_MST), .W(DW), .IW(MIDX_W)) u_wmux (
        .sel  (dp_mst_q),
        .din  (m_wdata),
        .dout (s_wdata)
    );

    resp_e def_resp;
    logic  def_ready;

    ic_default_slave u_def (
        .clk       (clk),
        .rst       (rst),
        .sel       (ap_slv == DEF_IDX),
        .trans     (ap_ctl.trans),
        .bus_ready (bus_ready),
        .ready_out (def_ready),
        .resp      (def_resp)
    );

    resp_e rsp_sel;

    ic_rsp_mux u_rmux (
        .idx       (dp_slv_q),
        .rdata     (s_rdata),
        .resp      (s_resp),
        .ready     (s_ready_out),
        .def_resp  (def_resp),
        .def_ready (def_ready),
        .rdata_out (m_rdata),
        .resp_out  (rsp_sel),
        .ready_out (bus_ready)
    );
    assign m_resp = rsp_sel;
endmodule

// File: rtl/ic_checker.sv
module ic_checker
    import bus_ic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_ready,
    input logic [1:0]        m_resp,
    input logic [AW-1:0]     s_addr,
    input logic [N_SLV-1:0]  s_sel,
    input logic [DW-1:0]     s_wdata,
    input logic [SIDX_W-1:0] dp_slv,
    input logic [MIDX_W-1:0] dp_mst
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_sel)); // R2
    AST_UNMAPPED_NOSEL: assert property (@(posedge clk) disable iff (rst)
        (s_addr[AW-1:REG_LSB+REG_W] != '0) |-> (s_sel == '0)); // R2
    AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |=> ($stable(dp_slv) && $stable(dp_mst))); // R3
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |=> $stable(s_wdata)); // R5
    AST_ERR_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (m_resp == RSP_ERROR && !bus_ready) |=> (m_resp == RSP_ERROR && bus_ready)); // R6
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bus_ready && m_resp == RSP_OKAY)); // R8
endmodule

bind shared_bus_ic ic_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ready (bus_ready),
    .m_resp    (m_resp),
    .s_addr    (s_addr),
    .s_sel     (s_sel),
    .s_wdata   (s_wdata),
    .dp_slv    (dp_slv_q),
    .dp_mst    (dp_mst_q)
);

// File: tb/sim_shared_bus_ic.sv
module sim_shared_bus_ic;
    import bus_ic_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                  rst;
    logic [MIDX_W-1:0]     grant;
    logic [N_MST*AW-1:0]   m_addr;
    logic [N_MST*2-1:0]    m_trans;
    logic [N_MST-1:0]      m_write;
    logic [N_MST*SZ_W-1:0] m_size;
    logic [N_MST*BU_W-1:0] m_burst;
    logic [N_MST*DW-1:0]   m_wdata;
    logic [DW-1:0]         m_rdata;
    logic [1:0]            m_resp;
    logic                  bus_ready;
    logic [AW-1:0]         s_addr;
    logic [1:0]            s_trans;
    logic                  s_write;
    logic [SZ_W-1:0]       s_size;
    logic [BU_W-1:0]       s_burst;
    logic [DW-1:0]         s_wdata;
    logic [N_SLV-1:0]      s_sel;
    logic [N_SLV*DW-1:0]   s_rdata;
    logic [N_SLV*2-1:0]    s_resp;
    logic [N_SLV-1:0]      s_ready_out;

    shared_bus_ic u0 (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench-side view of the address phase and the data phase.
    int          ap_g;
    logic [31:0] ap_a  [N_MST];
    logic [1:0]  ap_t  [N_MST];
    logic        ap_w  [N_MST];
    logic [2:0]  ap_sz [N_MST];

    bit          dp_v, dp_act, dp_w;
    int          dp_m, dp_s, dp_wait, dp_errc;
    logic [31:0] dp_a;

    function automatic int region(input logic [31:0] a);
        return (a[31:30] != 2'b00) ? 4 : int'(a[29:28]);
    endfunction

    function automatic logic [31:0] rd_pat(input int s, input logic [31:0] a);
        return (a ^ 32'h3C5A_0F96) + 32'(s) * 32'h0101_0001;
    endfunction

    function automatic logic [31:0] wr_pat(input int m, input logic [31:0] a);
        return ~a ^ (32'(m + 1) * 32'h1111_0000);
    endfunction

    task automatic new_ap(input int k);
        for (int m = 0; m < N_MST; m++) begin
            int r = $urandom_range(0, 9);
            logic [1:0] top = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            ap_a[m]  = {top, 2'($urandom_range(0, 3)), 28'($urandom)};
            ap_t[m]  = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : (r < 4) ? 2'b11 : 2'b10;
            ap_w[m]  = 1'($urandom);
            ap_sz[m] = 3'($urandom_range(0, 2));
        end
        ap_g = $urandom_range(0, N_MST - 1);
        if (k >= 0 && k < 30) begin
            // Directed sweep: every master, every region, every wait count.
            ap_g = k % 3;
            ap_a[ap_g] = {((k % 5) == 4) ? 2'b01 : 2'b00, 2'(k % 5),
                          24'($urandom), 2'((k / 5) % 4), 2'b00};
            ap_t[ap_g] = (k == 9 || k == 14) ? 2'b00 : 2'b10;
            ap_w[ap_g] = k[0];
        end
    endtask

    task automatic drive();
        grant = MIDX_W'(ap_g);
        for (int m = 0; m < N_MST; m++) begin
            m_addr[m*AW +: AW]       = ap_a[m];
            m_trans[m*2 +: 2]        = ap_t[m];
            m_write[m]               = ap_w[m];
            m_size[m*SZ_W +: SZ_W]   = ap_sz[m];
            m_burst[m*BU_W +: BU_W]  = 3'b000;
            m_wdata[m*DW +: DW]      = (dp_v && dp_m == m) ? wr_pat(m, dp_a) : $urandom;
        end
        for (int s = 0; s < N_SLV; s++) begin
            s_ready_out[s]      = !(dp_v && dp_act && dp_s == s && dp_wait > 0);
            s_resp[s*2 +: 2]    = 2'b00;
            s_rdata[s*DW +: DW] = (dp_v && dp_s == s) ? rd_pat(s, dp_a) : $urandom;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst     = 1'b1;
        dp_v    = 1'b0;
        dp_act  = 1'b0;
        dp_w    = 1'b0;
        dp_m    = 0;
        dp_s    = 4;
        dp_wait = 0;
        dp_errc = 0;
        dp_a    = '0;
        new_ap(0);
        drive();
        repeat (3) @(negedge clk);
        #2;
        chk("R8 ready in reset", 32'(bus_ready), 32'd1);
        chk("R8 resp in reset", 32'(m_resp), 32'd0);
        chk("R8 rdata in reset", m_rdata, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        begin
            int k = 1;
            for (int cyc = 0; cyc < 4000; cyc++) begin
                bit exp_rdy;
                int r;
                logic [N_SLV-1:0] exp_sel;
                drive();
                #2;
                if (!dp_v || !dp_act) exp_rdy = 1'b1;
                else if (dp_s < 4)    exp_rdy = (dp_wait == 0);
                else                  exp_rdy = (dp_errc == 1);

                chk((dp_v && dp_s == 4) ? "R6 ready" : "R3 ready", 32'(bus_ready), 32'(exp_rdy));
                chk("R1 addr", s_addr, ap_a[ap_g]);
                chk("R1 control", {26'd0, s_trans, s_write, s_size},
                    {26'd0, ap_t[ap_g], ap_w[ap_g], ap_sz[ap_g]});
                r = region(ap_a[ap_g]);
                exp_sel = (r < 4) ? N_SLV'(1 << r) : '0;
                chk("R2 select", 32'(s_sel), 32'(exp_sel));

                if (!dp_v) begin
                    chk("R8 resp after reset", 32'(m_resp), 32'd0);
                    chk("R8 rdata after reset", m_rdata, 32'd0);
                end else if (!dp_act) begin
                    chk((dp_s == 4) ? "R7 idle resp" : "R4 idle resp", 32'(m_resp), 32'd0);
                end else if (dp_s < 4) begin
                    if (dp_w) chk("R5 wdata", s_wdata, wr_pat(dp_m, dp_a));
                    if (exp_rdy) begin
                        chk("R4 resp", 32'(m_resp), 32'd0);
                        if (!dp_w) chk("R4 rdata", m_rdata, rd_pat(dp_s, dp_a));
                    end
                end else begin
                    chk("R6 error resp", 32'(m_resp), 32'd1);
                    if (exp_rdy && !dp_w) chk("R6 zero rdata", m_rdata, 32'd0);
                end

                if (exp_rdy) begin
                    dp_v    = 1'b1;
                    dp_m    = ap_g;
                    dp_a    = ap_a[ap_g];
                    dp_s    = region(dp_a);
                    dp_act  = ap_t[ap_g][1];
                    dp_w    = ap_w[ap_g];
                    dp_wait = (dp_s < 4 && dp_act) ? int'(dp_a[3:2]) : 0;
                    dp_errc = 0;
                    new_ap(k);
                    k++;
                end else begin
                    if (dp_s < 4) dp_wait--;
                    else          dp_errc++;
                    // Stalled address phase may change: owners must not.
                    if (k >= 30 && $urandom_range(0, 3) == 0) new_ap(-1);
                end
                @(negedge clk);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule